// File: doc/BRIEF.md
# Instruction Fetch Unit with Compressed-Instruction Assembly

This block supplies instruction words to a core that executes both full 32-bit instructions and 16-bit compressed ones. The core presents a fetch address together with a compressed-mode flag; the block answers with a single 32-bit instruction word on a one-cycle response strobe. Word fetches go through a small direct-mapped instruction cache. Each line of that cache keeps the complete fetch address as its tag and one instruction word as its data.

When compressed mode is set and the address lands on the upper halfword of a word (address modulo 4 equal to 2), the cache is not used. The block reads the halfword at the address through its memory port. It then decides from that halfword's two lowest bits whether a second halfword, at address+2, is needed to complete the instruction. A flush strobe invalidates the whole cache in one cycle. A single outstanding request/response memory port serves both word reads and halfword reads.

Top module: `insn_fetch`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0, and every cache line is invalid, so the first fetch of any address reads memory.
- R2: A word fetch that misses issues exactly one memory read with mem_req_half=0 at the request address. It returns mem_rsp_data as rsp_insn and fills the line, so a repeat fetch of that address reads no memory.
- R3: A word fetch that hits raises rsp_valid in the cycle right after the request is accepted, issues no memory read and returns the stored word, even if memory has since changed.
- R4: The line is chosen by address bits [9:2] (address/4 modulo 256 at the default size). A hit needs the stored full address to equal the request address. A different address with the same index misses and replaces the line.
- R5: With req_cmode=1 and address bits [1:0]=2'b10, the block first reads the halfword at the address with mem_req_half=1 (data in mem_rsp_data[15:0]). If that halfword's bits [1:0] are 2'b11, it then reads the halfword at address+2 and returns {second, first}.
- R6: In the R5 case, when the first halfword's bits [1:0] are not 2'b11, exactly one memory read is made and rsp_insn[31:16] is zero.
- R7: A mid-word compressed fetch neither reads nor writes the cache: repeating it reads memory again, and a line cached under the same index still hits afterwards.
- R8: With req_cmode=0, or with address bits [1:0] other than 2'b10, the fetch takes the cache path of R2 to R4, including addresses whose bits [1:0] are 2'b10.
- R9: A one-cycle flush invalidates every line, so the next fetch of any previously cached address misses.
- R10: When flush coincides with the cycle in which a miss response arrives, the response is still returned but the line is left invalid.
- R11: mem_req_valid and mem_req_addr hold steady while mem_req_ready is low, and the fetch completes correctly after any stall and response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can accept a fetch request |
| req_addr | input | ADDR_W | Fetch byte address |
| req_cmode | input | 1 | Compressed instructions enabled for this fetch |
| flush | input | 1 | Invalidate all cache lines |
| rsp_valid | output | 1 | One-cycle strobe: rsp_insn is valid |
| rsp_insn | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Memory read byte address |
| mem_req_half | output | 1 | 1: 16-bit read, 0: 32-bit read |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_data | input | 32 | Read data; halfword reads use bits [15:0] |

## Verification
A flush and a miss fill can fall in the same cycle: the memory response that would write a line arrives together with the invalidation strobe. The bench provokes this by having its memory model raise flush on exactly the cycle it presents the miss data. It then judges the outcome by checking that the response still carries the right word and that a repeat fetch of that address reads memory again instead of hitting.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_WREQ,
      FS_WRSP,
      FS_LREQ,
      FS_LRSP,
      FS_HREQ,
      FS_HRSP
   } fetch_state_e;

   localparam int INSN_W = 32;
   localparam int HALF_W = 16;

   // a halfword opens a full-width instruction only when both low bits are set
   function automatic logic needs_upper(input logic [HALF_W-1:0] h);
      return h[1:0] == 2'b11;
   endfunction

endpackage

// File: rtl/icache_store.sv
module icache_store #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              flush,
   output logic              any_valid
);

   localparam int ENTRIES = 1 << IDX_W;

   logic [ENTRIES-1:0] valid_q;
   logic [ADDR_W-1:0]  tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [IDX_W-1:0]   lk_idx;
   logic [IDX_W-1:0]   wr_idx;

   assign lk_idx = lk_addr[IDX_W+1:2];
   assign wr_idx = wr_addr[IDX_W+1:2];

   // flush takes priority over a fill landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_addr;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_addr);
   assign lk_data   = data_q[lk_idx];
   assign any_valid = |valid_q;

endmodule

// File: rtl/halfword_join.sv
module halfword_join
   import ifetch_pkg::*;
#(
   parameter bit CMODE_EN = 1'b1
) (
   input  logic [HALF_W-1:0] lo,
   input  logic [HALF_W-1:0] hi,
   output logic              want_hi,
   output logic [INSN_W-1:0] insn
);

   if (CMODE_EN) begin : g_join
      assign want_hi = needs_upper(lo);
      assign insn    = want_hi ? {hi, lo} : {{HALF_W{1'b0}}, lo};
   end else begin : g_flat
      assign want_hi = 1'b1;
      assign insn    = {hi, lo};
   end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
   import ifetch_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit CMODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_cmode,
   input  logic              lk_hit,
   input  logic [INSN_W-1:0] lk_data,
   output logic              fill_en,
   output logic [ADDR_W-1:0] fill_addr,
   output logic [INSN_W-1:0] fill_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              mem_req_half,
   input  logic              mem_rsp_valid,
   input  logic [INSN_W-1:0] mem_rsp_data,
   output logic              rsp_valid,
   output logic [INSN_W-1:0] rsp_insn,
   output logic              mid_q
);

   fetch_state_e      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [HALF_W-1:0] lo_q;
   logic              rsp_valid_q;
   logic [INSN_W-1:0] rsp_q;
   logic              accept;
   logic              mid_now;
   logic [HALF_W-1:0] join_lo;
   logic              join_want_hi;
   logic [INSN_W-1:0] join_insn;

   assign req_ready = (state_q == FS_IDLE);
   assign accept    = req_valid && req_ready;
   assign mid_now   = CMODE_EN && req_cmode && (req_addr[1:0] == 2'b10);

   assign join_lo = (state_q == FS_HRSP) ? lo_q : mem_rsp_data[HALF_W-1:0];

   halfword_join #(.CMODE_EN(CMODE_EN)) i_join (
      .lo      (join_lo),
      .hi      (mem_rsp_data[HALF_W-1:0]),
      .want_hi (join_want_hi),
      .insn    (join_insn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= FS_IDLE;
         addr_q      <= '0;
         lo_q        <= '0;
         mid_q       <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_q       <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: begin
               if (accept) begin
                  addr_q <= req_addr;
                  mid_q  <= mid_now;
                  if (mid_now) begin
                     state_q <= FS_LREQ;
                  end else if (lk_hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_q       <= lk_data;
                  end else begin
                     state_q <= FS_WREQ;
                  end
               end
            end
            FS_WREQ: if (mem_req_ready) state_q <= FS_WRSP;
            FS_WRSP: begin
               if (mem_rsp_valid) begin
                  rsp_valid_q <= 1'b1;
                  rsp_q       <= mem_rsp_data;
                  state_q     <= FS_IDLE;
               end
            end
            FS_LREQ: if (mem_req_ready) state_q <= FS_LRSP;
            FS_LRSP: begin
               if (mem_rsp_valid) begin
                  lo_q <= mem_rsp_data[HALF_W-1:0];
                  if (join_want_hi) begin
                     state_q <= FS_HREQ;
                  end else begin
                     rsp_valid_q <= 1'b1;
                     rsp_q       <= join_insn;
                     state_q     <= FS_IDLE;
                  end
               end
            end
            FS_HREQ: if (mem_req_ready) state_q <= FS_HRSP;
            FS_HRSP: begin
               if (mem_rsp_valid) begin
                  rsp_valid_q <= 1'b1;
                  rsp_q       <= join_insn;
                  state_q     <= FS_IDLE;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == FS_WREQ) || (state_q == FS_LREQ) ||
                          (state_q == FS_HREQ);
   assign mem_req_half  = (state_q == FS_LREQ) || (state_q == FS_HREQ);
   assign mem_req_addr  = (state_q == FS_HREQ) ? addr_q + ADDR_W'(2) : addr_q;

   assign fill_en   = (state_q == FS_WRSP) && mem_rsp_valid;
   assign fill_addr = addr_q;
   assign fill_data = mem_rsp_data;

   assign rsp_valid = rsp_valid_q;
   assign rsp_insn  = rsp_q;

endmodule

// File: rtl/insn_fetch.sv
module insn_fetch
   import ifetch_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 8,
   parameter bit CMODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_cmode,
   input  logic              flush,
   output logic              rsp_valid,
   output logic [31:0]       rsp_insn,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              mem_req_half,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data
);

   if (ADDR_W < IDX_W + 2) begin : g_bad_addr_w
      $error("insn_fetch: ADDR_W must cover the index and byte offset");
   end
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx_w
      $error("insn_fetch: IDX_W out of range 1..12");
   end

   logic              lk_hit;
   logic [INSN_W-1:0] lk_data;
   logic              fill_en;
   logic [ADDR_W-1:0] fill_addr;
   logic [INSN_W-1:0] fill_data;
   logic              any_valid;
   logic              mid_q;

   icache_store #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .DATA_W (INSN_W)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_addr   (req_addr),
      .lk_hit    (lk_hit),
      .lk_data   (lk_data),
      .wr_en     (fill_en),
      .wr_addr   (fill_addr),
      .wr_data   (fill_data),
      .flush     (flush),
      .any_valid (any_valid)
   );

   fetch_ctrl #(
      .ADDR_W   (ADDR_W),
      .CMODE_EN (CMODE_EN)
   ) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_cmode     (req_cmode),
      .lk_hit        (lk_hit),
      .lk_data       (lk_data),
      .fill_en       (fill_en),
      .fill_addr     (fill_addr),
      .fill_data     (fill_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_half  (mem_req_half),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_insn      (rsp_insn),
      .mid_q         (mid_q)
   );

endmodule

// File: rtl/fetch_chk.sv
module fetch_chk #(
   parameter int ADDR_W   = 32,
   parameter bit CMODE_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_addr_lo,
   input logic              req_cmode,
   input logic              flush,
   input logic              rsp_valid,
   input logic [15:0]       rsp_hi,
   input logic [1:0]        rsp_lo2,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_req_half,
   input logic              lk_hit,
   input logic              mid_q,
   input logic              any_valid
);

   logic word_hit;
   assign word_hit = req_valid && req_ready && lk_hit &&
                     !(CMODE_EN && req_cmode && req_addr_lo == 2'b10);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);                                   // R1

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_hit |=> rsp_valid);                                         // R3

   AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      word_hit |=> !mem_req_valid);                                    // R3

   AST_MID_HALF_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mid_q) |-> mem_req_half);                      // R5

   AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && mid_q && rsp_lo2 != 2'b11) |-> rsp_hi == 16'h0);   // R6

   AST_WORD_FULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mid_q) |-> !mem_req_half);                    // R8

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !any_valid);                                           // R9

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr)));                    // R11

endmodule

bind insn_fetch fetch_chk #(
   .ADDR_W   (ADDR_W),
   .CMODE_EN (CMODE_EN)
) i_fetch_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr_lo   (req_addr[1:0]),
   .req_cmode     (req_cmode),
   .flush         (flush),
   .rsp_valid     (rsp_valid),
   .rsp_hi        (rsp_insn[31:16]),
   .rsp_lo2       (rsp_insn[1:0]),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_half  (mem_req_half),
   .lk_hit        (lk_hit),
   .mid_q         (mid_q),
   .any_valid     (any_valid)
);

// File: tb/test_insn_fetch.sv
module test_insn_fetch;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic        req_cmode;
   logic        flush;
   logic        rsp_valid;
   logic [31:0] rsp_insn;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_req_half;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] mem [1024];
   int mem_lat;
   int memcnt;
   int flush_ask, flush_arm, stall_ask;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_fetch i_insn_fetch (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_cmode(req_cmode), .flush(flush),
      .rsp_valid(rsp_valid), .rsp_insn(rsp_insn),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_half(mem_req_half),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   function automatic logic [15:0] half_at(input logic [31:0] a);
      return a[1] ? mem[a[11:2]][31:16] : mem[a[11:2]][15:0];
   endfunction

   function automatic logic [31:0] expect_insn(input logic [31:0] a, input logic cm);
      logic [15:0] lo;
      if (cm && a[1:0] == 2'b10) begin
         lo = half_at(a);
         if (lo[1:0] == 2'b11) return {half_at(a + 32'd2), lo};
         return {16'h0, lo};
      end
      return mem[a[11:2]];
   endfunction

   // memory model: sole driver of the memory-side inputs and of flush
   initial begin : mem_model
      bit pend = 0;
      int wcnt = 0;
      int flush_done = 0, arm_done = 0, stall_done = 0;
      logic [31:0] pdata = '0;
      mem_req_ready = 1'b1;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      flush         = 1'b0;
      memcnt        = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         flush         = 1'b0;
         if (stall_done < stall_ask) begin
            mem_req_ready = 1'b0;
            stall_done++;
         end else begin
            mem_req_ready = 1'b1;
         end
         if (flush_done < flush_ask) begin
            flush = 1'b1;
            flush_done++;
         end
         if (pend) begin
            if (wcnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pdata;
               pend = 0;
               if (arm_done < flush_arm) begin
                  flush = 1'b1;
                  arm_done++;
               end
            end else begin
               wcnt--;
            end
         end else if (mem_req_valid && mem_req_ready) begin
            pend = 1;
            wcnt = mem_lat;
            memcnt++;
            pdata = mem_req_half ? {16'h0, half_at(mem_req_addr)} : mem[mem_req_addr[11:2]];
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fetch(input logic [31:0] a, input logic cm,
                        output logic [31:0] ins, output int lat, output int nreq);
      int n0;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_cmode = cm;
      while (!req_ready) @(negedge clk);
      n0 = memcnt;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 500) begin
         @(negedge clk);
         lat++;
      end
      ins  = rsp_insn;
      nreq = memcnt - n0;
   endtask

   task automatic t_reset;
      check("R1 req_ready", 32'(req_ready), 32'd1);
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
      check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
   endtask

   task automatic t_miss_hit;
      logic [31:0] ins, old; int lat, nr;
      mem[10'h040] = 32'h1234_5677;
      fetch(32'h100, 1'b0, ins, lat, nr);
      check("R1 first fetch reads memory", 32'(nr), 32'd1);
      check("R2 miss data", ins, 32'h1234_5677);
      old = mem[10'h040];
      mem[10'h040] = 32'hDEAD_0001;
      fetch(32'h100, 1'b0, ins, lat, nr);
      check("R2 refetch no memory read", 32'(nr), 32'd0);
      check("R3 hit returns stored word", ins, old);
      check("R3 hit latency one cycle", 32'(lat), 32'd1);
   endtask

   task automatic t_conflict;
      logic [31:0] ins; int lat, nr;
      mem[10'h140] = 32'hCAFE_0013;
      fetch(32'h500, 1'b0, ins, lat, nr);
      check("R4 same index other tag misses", 32'(nr), 32'd1);
      check("R4 conflict data", ins, 32'hCAFE_0013);
      fetch(32'h100, 1'b0, ins, lat, nr);
      check("R4 evicted line misses", 32'(nr), 32'd1);
      check("R4 refilled data", ins, mem[10'h040]);
   endtask

   task automatic t_mid_long;
      logic [31:0] ins; int lat, nr;
      mem[10'h082] = 32'hBEE3_0000;
      mem[10'h083] = 32'h0000_7F0F;
      fetch(32'h20A, 1'b1, ins, lat, nr);
      check("R5 two halfword reads", 32'(nr), 32'd2);
      check("R5 joined word", ins, expect_insn(32'h20A, 1'b1));
      check("R5 joined word literal", ins, 32'h7F0F_BEE3);
   endtask

   task automatic t_mid_short;
      logic [31:0] ins; int lat, nr;
      mem[10'h0C3] = 32'h4A52_0F0F;
      fetch(32'h30E, 1'b1, ins, lat, nr);
      check("R6 single read", 32'(nr), 32'd1);
      check("R6 upper zero", ins, 32'h0000_4A52);
   endtask

   task automatic t_bypass;
      logic [31:0] ins; int lat, nr;
      fetch(32'h30C, 1'b0, ins, lat, nr);
      check("R7 line cached miss", 32'(nr), 32'd1);
      fetch(32'h30E, 1'b1, ins, lat, nr);
      check("R7 mid fetch reads memory", 32'(nr), 32'd1);
      fetch(32'h30E, 1'b1, ins, lat, nr);
      check("R7 mid fetch not cached", 32'(nr), 32'd1);
      fetch(32'h30C, 1'b0, ins, lat, nr);
      check("R7 same index line still hits", 32'(nr), 32'd0);
      check("R7 same index data", ins, 32'h4A52_0F0F);
   endtask

   task automatic t_word_path;
      logic [31:0] ins; int lat, nr;
      fetch(32'h30E, 1'b0, ins, lat, nr);
      check("R8 cmode off offset 2 is word miss", 32'(nr), 32'd1);
      check("R8 word data", ins, mem[10'h0C3]);
      fetch(32'h30E, 1'b0, ins, lat, nr);
      check("R8 cmode off offset 2 hits", 32'(nr), 32'd0);
      fetch(32'h100, 1'b1, ins, lat, nr);
      check("R8 cmode on aligned uses cache", 32'(nr), 32'd0);
      check("R8 cmode on aligned latency", 32'(lat), 32'd1);
   endtask

   task automatic t_flush;
      logic [31:0] ins; int lat, nr;
      fetch(32'h100, 1'b0, ins, lat, nr);
      check("R9 precondition hit", 32'(nr), 32'd0);
      mem[10'h040] = 32'h0BAD_F00D;
      flush_ask++;
      repeat (3) @(negedge clk);
      fetch(32'h100, 1'b0, ins, lat, nr);
      check("R9 after flush misses", 32'(nr), 32'd1);
      check("R9 new data after flush", ins, 32'h0BAD_F00D);
      fetch(32'h30C, 1'b0, ins, lat, nr);
      check("R9 other line also flushed", 32'(nr), 32'd1);
   endtask

   task automatic t_flush_fill;
      logic [31:0] ins; int lat, nr;
      mem[10'h1F0] = 32'h5555_AAAB;
      flush_arm++;
      fetch(32'h7C0, 1'b0, ins, lat, nr);
      check("R10 response still returned", ins, 32'h5555_AAAB);
      fetch(32'h7C0, 1'b0, ins, lat, nr);
      check("R10 line left invalid", 32'(nr), 32'd1);
      fetch(32'h7C0, 1'b0, ins, lat, nr);
      check("R10 later fill works", 32'(nr), 32'd0);
   endtask

   task automatic t_stall;
      logic [31:0] ins; int lat, nr;
      mem[10'h100] = 32'h0246_8ACF;
      mem_lat = 3;
      stall_ask += 6;
      fetch(32'h400, 1'b0, ins, lat, nr);
      check("R11 stalled word data", ins, 32'h0246_8ACF);
      check("R11 stalled single read", 32'(nr), 32'd1);
      mem[10'h102] = 32'h1113_0000;
      mem[10'h103] = 32'h0000_2221;
      stall_ask += 4;
      fetch(32'h40A, 1'b1, ins, lat, nr);
      check("R11 stalled joined word", ins, 32'h2221_1113);
      mem_lat = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      flush_ask = 0;
      flush_arm = 0;
      stall_ask = 0;
      mem_lat   = 0;
      for (int i = 0; i < 1024; i++)
         mem[i] = {16'(i * 37 + 16'h4000), 16'(i * 53 + 1)};
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_addr  = '0;
      req_cmode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_miss_hit();
      t_conflict();
      t_mid_long();
      t_mid_short();
      t_bypass();
      t_word_path();
      t_flush();
      t_flush_fill();
      t_stall();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule